// File: doc/BRIEF.md
# Four-Port Input-Queued Packet Switch

This block moves packets of 16-bit flits from any of four ingress ports to any of four egress ports. Each ingress port queues arriving flits in its own first-in first-out buffer. A small per-port route machine reads the destination from the first flit of each packet and keeps that destination until the packet's last flit has left. Each egress port has its own arbiter that picks one requesting ingress port with a rotating priority. The arbiter keeps that connection until the whole packet has crossed.

Every port uses a valid/ready handshake, and a flit moves on any cycle where both are high. A grant is made in the same cycle that a request appears, so a flit can leave on the cycle after it was accepted at the ingress. Each ingress port has only one queue. If the packet at the head of that queue is waiting for a busy egress port, every packet behind it waits too, even when those packets are bound for idle egress ports.

Top module: `xbar_switch`

## Requirements
- R1: After reset, every ingress ready output is high and every egress valid output is low.
- R2: Flit bits [15:14] give the flit kind: 2'b01 opens a packet, 2'b00 is a middle flit, 2'b10 closes a packet, and 2'b11 is a packet of one flit. The destination egress port is in bits [1:0] of an opening or one-flit packet. A one-flit packet appears unchanged on the egress port it names and on no other.
- R3: The flits of a multi-flit packet leave their egress port back to back, in order, and no other ingress port is granted that egress port until the closing flit has been accepted. This holds even when the sender pauses in the middle of the packet.
- R4: Each egress arbiter uses rotating priority. The ingress port it most recently selected gets the lowest priority next time, and after reset ingress port 0 ranks highest.
- R5: Different egress ports may each serve a different ingress port in the same cycle. No ingress port is ever granted by two egress ports at once.
- R6: Each ingress port delivers packets strictly in arrival order. A packet queued behind a blocked head packet is not delivered before that head packet, even if its own egress port is idle.
- R7: Each ingress buffer holds 8 flits. Its ready output is low while the buffer is full, and no accepted flit is lost or reordered.
- R8: While an egress port shows valid and its ready is low, valid stays high and the egress data holds steady on the next cycle.
- R9: A middle or closing flit that reaches the head of an ingress buffer outside a packet is discarded and never appears on any egress port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 4 | Per-ingress flit valid |
| in_data | input | 64 | Ingress flits, port p in bits [16p+15:16p] |
| in_ready | output | 4 | Per-ingress ready (buffer not full) |
| out_valid | output | 4 | Per-egress flit valid |
| out_data | output | 64 | Egress flits, port p in bits [16p+15:16p] |
| out_ready | input | 4 | Per-egress ready from the downstream side |

## Verification
Errors in the arbiter lock state show up at the egress ports at once. If a packet is released too early, flits from two ingress ports mix on one egress port within a single flit time. If a grant is held too long, an egress port goes silent after a closing flit while another ingress port still has flits waiting for it. A wrong rotation pointer shows as the wrong delivery order after the very first contested decision. A route machine that loses or drops its latched destination sends the next middle flit to the wrong egress port, or lets a blocked follower packet overtake its head. Both can be seen in the logged egress sequence for that packet.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    typedef enum logic [1:0] {
        FK_MID    = 2'b00,
        FK_OPEN   = 2'b01,
        FK_CLOSE  = 2'b10,
        FK_SINGLE = 2'b11
    } flit_kind_e;

    function automatic flit_kind_e kind_of(input logic [1:0] tag);
        return flit_kind_e'(tag);
    endfunction

    function automatic logic starts_packet(input logic [1:0] tag);
        return (tag == FK_OPEN) || (tag == FK_SINGLE);
    endfunction

    function automatic logic ends_packet(input logic [1:0] tag);
        return (tag == FK_CLOSE) || (tag == FK_SINGLE);
    endfunction
endpackage

// File: rtl/xbar_fifo.sv
module xbar_fifo #(
    parameter int FW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [FW-1:0] din,
    input  logic          pop,
    output logic [FW-1:0] dout,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fstate_t;

    fstate_t       st_d, st_q;
    logic [FW-1:0] mem_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (pop) begin
            st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        if (push && !pop) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (pop && !push) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[st_q.wr] <= din;
        end
    end

    assign dout  = mem_q[st_q.rd];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
endmodule

// File: rtl/xbar_route.sv
module xbar_route #(
    parameter int NP = 4,
    parameter int FW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [FW-1:0]          head,
    input  logic                   empty,
    input  logic                   sent,
    output logic                   req,
    output logic [$clog2(NP)-1:0]  dest,
    output logic                   drop
);
    import xbar_pkg::*;

    localparam int PW = $clog2(NP);

    typedef struct packed {
        logic          busy;
        logic [PW-1:0] dest;
    } rstate_t;

    rstate_t    st_d, st_q;
    logic [1:0] tag;

    assign tag  = head[FW-1:FW-2];
    assign req  = !empty && (st_q.busy || starts_packet(tag));
    assign dest = st_q.busy ? st_q.dest : head[PW-1:0];
    assign drop = !empty && !st_q.busy && !starts_packet(tag);

    always_comb begin
        st_d = st_q;
        if (sent) begin
            case (kind_of(tag))
                FK_OPEN: begin
                    st_d.busy = 1'b1;
                    st_d.dest = head[PW-1:0];
                end
                FK_CLOSE, FK_SINGLE: st_d.busy = 1'b0;
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/xbar_arb.sv
module xbar_arb #(
    parameter int NP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] req,
    input  logic          ready,
    input  logic [1:0]    tag,
    output logic [NP-1:0] gnt
);
    import xbar_pkg::*;

    localparam int PW = $clog2(NP);

    typedef struct packed {
        logic          locked;
        logic [PW-1:0] owner;
        logic [PW-1:0] last;
    } astate_t;

    astate_t       st_d, st_q;
    logic          found;
    logic [PW-1:0] pick;
    logic [PW-1:0] cur;
    logic          active;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 1; k <= NP; k++) begin
            if (!found && req[(int'(st_q.last) + k) % NP]) begin
                found = 1'b1;
                pick  = PW'((int'(st_q.last) + k) % NP);
            end
        end
    end

    always_comb begin
        if (st_q.locked) begin
            cur    = st_q.owner;
            active = req[st_q.owner];
        end else begin
            cur    = pick;
            active = found;
        end
        gnt      = '0;
        gnt[cur] = active;
    end

    always_comb begin
        st_d = st_q;
        if (active && !st_q.locked) begin
            st_d.last = cur;
        end
        if (active) begin
            if (!ready) begin
                st_d.locked = 1'b1;
                st_d.owner  = cur;
            end else if (kind_of(tag) == FK_OPEN) begin
                st_d.locked = 1'b1;
                st_d.owner  = cur;
            end else if (ends_packet(tag)) begin
                st_d.locked = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.locked <= 1'b0;
            st_q.owner  <= '0;
            st_q.last   <= PW'(NP - 1);
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/xbar_switch.sv
module xbar_switch #(
    parameter int NP    = 4,
    parameter int FW    = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NP-1:0]    in_valid,
    input  logic [NP*FW-1:0] in_data,
    output logic [NP-1:0]    in_ready,
    output logic [NP-1:0]    out_valid,
    output logic [NP*FW-1:0] out_data,
    input  logic [NP-1:0]    out_ready
);
    localparam int PW = $clog2(NP);

    logic [FW-1:0]    head_w [NP];
    logic [NP-1:0]    empty_w;
    logic [NP-1:0]    full_w;
    logic [NP-1:0]    req_w;
    logic [PW-1:0]    dest_w [NP];
    logic [NP-1:0]    drop_w;
    logic [NP-1:0]    sent_w;
    logic [NP*NP-1:0] req_flat;
    logic [NP*NP-1:0] gnt_flat;

    for (genvar i = 0; i < NP; i++) begin : g_in
        assign in_ready[i] = !full_w[i];

        xbar_fifo #(.FW(FW), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (in_valid[i] && !full_w[i]),
            .din   (in_data[i*FW +: FW]),
            .pop   (sent_w[i] || drop_w[i]),
            .dout  (head_w[i]),
            .empty (empty_w[i]),
            .full  (full_w[i])
        );

        xbar_route #(.NP(NP), .FW(FW)) u_route (
            .clk   (clk),
            .rst_n (rst_n),
            .head  (head_w[i]),
            .empty (empty_w[i]),
            .sent  (sent_w[i]),
            .req   (req_w[i]),
            .dest  (dest_w[i]),
            .drop  (drop_w[i])
        );
    end

    always_comb begin
        for (int o = 0; o < NP; o++) begin
            for (int i = 0; i < NP; i++) begin
                req_flat[o*NP + i] = req_w[i] && (dest_w[i] == PW'(o));
            end
        end
    end

    for (genvar o = 0; o < NP; o++) begin : g_out
        xbar_arb #(.NP(NP)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req_flat[o*NP +: NP]),
            .ready (out_ready[o]),
            .tag   (out_data[o*FW + FW - 2 +: 2]),
            .gnt   (gnt_flat[o*NP +: NP])
        );
        assign out_valid[o] = |gnt_flat[o*NP +: NP];
    end

    always_comb begin
        out_data = '0;
        for (int o = 0; o < NP; o++) begin
            for (int i = 0; i < NP; i++) begin
                if (gnt_flat[o*NP + i]) begin
                    out_data[o*FW +: FW] = out_data[o*FW +: FW] | head_w[i];
                end
            end
        end
    end

    always_comb begin
        sent_w = '0;
        for (int i = 0; i < NP; i++) begin
            for (int o = 0; o < NP; o++) begin
                sent_w[i] = sent_w[i] | (gnt_flat[o*NP + i] & out_ready[o]);
            end
        end
    end
endmodule

// File: rtl/xbar_switch_chk.sv
module xbar_switch_chk #(
    parameter int NP = 4,
    parameter int FW = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NP-1:0]    out_valid,
    input logic [NP-1:0]    out_ready,
    input logic [NP*FW-1:0] out_data,
    input logic [NP*NP-1:0] gnt_flat
);
    for (genvar o = 0; o < NP; o++) begin : g_o
        // R8: a stalled egress keeps its flit
        a_r8_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] && !out_ready[o] |=> out_valid[o]);
        a_r8_data_held: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] && !out_ready[o] |=> $stable(out_data[o*FW +: FW]));
        // R3: one owner per egress
        a_r3_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gnt_flat[o*NP +: NP]));
        for (genvar i = 0; i < NP; i++) begin : g_i
            // R3: after an opening flit is taken, no other ingress may be granted
            a_r3_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
                gnt_flat[o*NP + i] && out_ready[o] && (out_data[o*FW + FW - 2 +: 2] == 2'b01)
                |=> ((gnt_flat[o*NP +: NP] & ~(NP'(1) << i)) == '0));
        end
    end

    for (genvar i = 0; i < NP; i++) begin : g_col
        logic [NP-1:0] col;
        for (genvar o = 0; o < NP; o++) begin : g_bit
            assign col[o] = gnt_flat[o*NP + i];
        end
        // R5: one ingress never served by two egress ports
        a_r5_one_egress: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col));
    end
endmodule

bind xbar_switch xbar_switch_chk #(.NP(NP), .FW(FW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .gnt_flat  (gnt_flat)
);

// File: tb/tb_xbar_switch.sv
`timescale 1ns/1ps
module tb_xbar_switch;
    localparam int NP = 4;
    localparam int FW = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NP-1:0]    in_valid = '0;
    logic [NP*FW-1:0] in_data = '0;
    logic [NP-1:0]    in_ready;
    logic [NP-1:0]    out_valid;
    logic [NP*FW-1:0] out_data;
    logic [NP-1:0]    out_ready = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [FW-1:0] log_q [NP][16];
    int            stamp [NP][16];
    int            cnt   [NP];

    xbar_switch #(.NP(NP), .FW(FW), .DEPTH(8)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ready (out_ready)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        for (int o = 0; o < NP; o++) begin
            if (!rst_n) begin
                cnt[o] = 0;
            end else if (out_valid[o] && out_ready[o] && cnt[o] < 16) begin
                log_q[o][cnt[o]] = out_data[o*FW +: FW];
                stamp[o][cnt[o]] = cyc;
                cnt[o] = cnt[o] + 1;
            end
        end
    end

    function automatic logic [FW-1:0] mk(input logic [1:0] kind, input logic [11:0] pay,
                                         input logic [1:0] dst);
        return {kind, pay, dst};
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = '0;
        out_ready = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic push(input int p, input logic [FW-1:0] f);
        @(posedge clk);
        #1;
        in_valid[p] = 1'b1;
        in_data[p*FW +: FW] = f;
        @(negedge clk);
        while (!in_ready[p]) @(negedge clk);
        @(posedge clk);
        #1 in_valid[p] = 1'b0;
    endtask

    task automatic release_all();
        @(posedge clk);
        #1 out_ready = '1;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R1", "in_ready after reset", int'(in_ready), 'hF);
        chk("R1", "out_valid after reset", int'(out_valid), 0);
    endtask

    task automatic t_single();
        logic [FW-1:0] f;
        do_reset();
        out_ready = '1;
        f = mk(2'b11, 12'h5A3, 2'd2);
        push(0, f);
        repeat (4) @(negedge clk);
        chk("R2", "count on egress 2", cnt[2], 1);
        chk("R2", "data on egress 2", int'(log_q[2][0]), int'(f));
        chk("R2", "other egress counts", cnt[0] + cnt[1] + cnt[3], 0);
    endtask

    task automatic t_parallel();
        do_reset();
        for (int i = 0; i < NP; i++) push(i, mk(2'b11, 12'(i + 'h100), 2'((i + 1) % NP)));
        release_all();
        repeat (3) @(negedge clk);
        for (int o = 0; o < NP; o++) begin
            chk("R5", "parallel count", cnt[o], 1);
            chk("R5", "parallel data", int'(log_q[o][0]),
                int'(mk(2'b11, 12'(((o + NP - 1) % NP) + 'h100), 2'(o))));
            chk("R5", "same-cycle delivery", stamp[o][0], stamp[0][0]);
        end
    endtask

    task automatic t_packet();
        logic [FW-1:0] exp [6];
        do_reset();
        exp[0] = mk(2'b01, 12'h010, 2'd1);
        exp[1] = mk(2'b00, 12'h011, 2'd0);
        exp[2] = mk(2'b10, 12'h012, 2'd3);
        exp[3] = mk(2'b01, 12'h020, 2'd1);
        exp[4] = mk(2'b00, 12'h021, 2'd2);
        exp[5] = mk(2'b10, 12'h022, 2'd0);
        for (int k = 0; k < 3; k++) push(0, exp[k]);
        for (int k = 3; k < 6; k++) push(1, exp[k]);
        release_all();
        repeat (10) @(negedge clk);
        chk("R3", "packet flit count", cnt[1], 6);
        for (int k = 0; k < 6; k++) chk("R3", "contiguous packet order", int'(log_q[1][k]), int'(exp[k]));
        chk("R4", "ingress 0 first after reset", int'(log_q[1][0][13:2]), 'h010);
    endtask

    task automatic t_rotate();
        do_reset();
        for (int i = 0; i < 3; i++) begin
            for (int n = 0; n < 2; n++) push(i, mk(2'b11, 12'(i * 16 + n), 2'd3));
        end
        release_all();
        repeat (10) @(negedge clk);
        chk("R4", "rotation count", cnt[3], 6);
        for (int k = 0; k < 6; k++)
            chk("R4", "rotating order", int'(log_q[3][k][13:2]), (k % 3) * 16 + (k / 3));
    endtask

    task automatic t_hol();
        do_reset();
        out_ready = '1;
        push(1, mk(2'b01, 12'h030, 2'd1));
        push(1, mk(2'b00, 12'h031, 2'd0));
        push(0, mk(2'b11, 12'h040, 2'd1));
        push(0, mk(2'b11, 12'h041, 2'd2));
        repeat (6) @(negedge clk);
        chk("R3", "egress 1 held for gapped packet", int'(out_valid[1]), 0);
        chk("R6", "follower waits behind blocked head", int'(out_valid[2]), 0);
        chk("R6", "nothing on egress 2 yet", cnt[2], 0);
        push(1, mk(2'b10, 12'h032, 2'd0));
        repeat (6) @(negedge clk);
        chk("R3", "egress 1 count", cnt[1], 4);
        chk("R3", "closing flit before other ingress", int'(log_q[1][2][13:2]), 'h032);
        chk("R6", "blocked head delivered after release", int'(log_q[1][3][13:2]), 'h040);
        chk("R6", "follower delivered", cnt[2], 1);
        chk("R6", "follower data", int'(log_q[2][0][13:2]), 'h041);
        chk("R6", "follower after head", int'(stamp[2][0] > stamp[1][3]), 1);
    endtask

    task automatic t_full();
        logic [FW-1:0] first;
        do_reset();
        first = mk(2'b11, 12'h200, 2'd0);
        for (int n = 0; n < 8; n++) push(2, mk(2'b11, 12'(n + 'h200), 2'd0));
        @(negedge clk);
        chk("R7", "ready low when full", int'(in_ready[2]), 0);
        chk("R7", "other ingress ready", int'(in_ready & 4'b1011), 'hB);
        chk("R8", "stalled valid", int'(out_valid[0]), 1);
        chk("R8", "stalled data", int'(out_data[0 +: FW]), int'(first));
        repeat (3) @(negedge clk);
        chk("R8", "stalled valid held", int'(out_valid[0]), 1);
        chk("R8", "stalled data held", int'(out_data[0 +: FW]), int'(first));
        release_all();
        repeat (12) @(negedge clk);
        chk("R7", "all buffered flits delivered", cnt[0], 8);
        for (int n = 0; n < 8; n++) chk("R7", "buffered order", int'(log_q[0][n][13:2]), n + 'h200);
        chk("R7", "ready back after drain", int'(in_ready[2]), 1);
    endtask

    task automatic t_drop();
        do_reset();
        out_ready = '1;
        push(3, mk(2'b00, 12'h077, 2'd0));
        push(3, mk(2'b10, 12'h078, 2'd1));
        push(3, mk(2'b11, 12'h079, 2'd0));
        repeat (4) @(negedge clk);
        chk("R9", "only the packet reaches egress 0", cnt[0], 1);
        chk("R9", "packet data", int'(log_q[0][0][13:2]), 'h079);
        chk("R9", "stray flits nowhere", cnt[1] + cnt[2] + cnt[3], 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_parallel();
        t_packet();
        t_rotate();
        t_hol();
        t_full();
        t_drop();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule